// File: doc/BRIEF.md
# Parallel Flash Write-Protect Sequencer

This block models the write-control front end of a byte-wide parallel NOR flash. It samples the chip-select, read-strobe and write-strobe inputs on the system clock. A write strobe is accepted only if it stays low long enough. Writes are refused while the supply is not yet trusted. A four-write command sequence unlocks a single byte program, which then runs for a fixed number of clock cycles. The storage behind it is a small register array. The array resets to the erased value 8'hFF, and a program can only clear bits.

Software learns that a program has finished by reading any address. While the program runs, each read returns a status byte instead of array data. That byte holds the inverted top bit of the data being programmed, and a bit that flips on every separate read. When the program timer runs out, the block goes back to plain reads without any action from software.

Top module: `pflash_wp_seq`

## Requirements
- R1: After reset every array byte reads as 8'hFF, no program is running and the command decoder is idle. A read is ce_n=0, oe_n=0, we_n=1, and rdata is 8'h00 whenever no read is active.
- R2: A completed program leaves the addressed byte equal to its old value AND the programmed data. No bit ever goes from 0 to 1.
- R3: A program starts only after four accepted writes: data 8'hAA to address 16'h5555, then 8'h55 to 16'h2AAA, then 8'hA0 to 16'h5555, then the target address and data. A write that does not match the expected step returns the decoder to idle.
- R4: A write is accepted when we_n goes high after being low for at least MIN_WE_CYC consecutive clock cycles, with ce_n low and oe_n high throughout. A shorter low pulse is ignored.
- R5: A write strobe is ignored if oe_n is low or ce_n is high during the pulse.
- R6: While pwr_good is low, and for LOCK_CYC cycles after it rises, a completed sequence starts no program.
- R7: While vdd_low is high, a completed sequence starts no program.
- R8: During a program, a read at any address returns bit 7 equal to the inverse of the programmed data bit 7, bit 6 changing on each separate read, and bits 5..0 zero.
- R9: A program ends on its own PROG_CYC cycles after the final write is accepted. Reads then return the true array data.
- R10: Writes that arrive while a program is running are ignored, including a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data |
| pwr_good | input | 1 | Supply has reached its operating level |
| vdd_low | input | 1 | Supply below the program threshold |
| rdata | output | 8 | Read data or program status |

## Verification
The bench sends a first unlock write whose pulse is one cycle too short, and others gated by a low read strobe or a high chip select. A filter that accepted any of these would reach the final step and change the byte. Complete sequences are sent just after pwr_good rises, while vdd_low is high, and while another program is running. An untimed lockout, a missing supply check or an unguarded decoder would then alter an array byte that must stay unchanged. Programs that try to set bits, together with the polled status bits, catch an array write that overwrites instead of ANDing, a wrong status polarity, and a toggle that stays fixed or never stops.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_ARM1,
      SEQ_ARM2,
      SEQ_LOAD
   } seq_state_e;

   localparam logic [15:0] KEY_ADDR_HI = 16'h5555;
   localparam logic [15:0] KEY_ADDR_LO = 16'h2AAA;
   localparam logic [7:0]  KEY_FIRST   = 8'hAA;
   localparam logic [7:0]  KEY_SECOND  = 8'h55;
   localparam logic [7:0]  KEY_PROGRAM = 8'hA0;
endpackage

// File: rtl/pflash_we_qual.sv
module pflash_we_qual #(
   parameter int AW         = 16,
   parameter int MIN_WE_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic          wr_valid,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data
);
   localparam int CW = $clog2(MIN_WE_CYC + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(MIN_WE_CYC);

   logic          strobe_ok;
   logic [CW-1:0] low_cnt;

   assign strobe_ok = !ce_n && oe_n && !we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         wr_addr <= '0;
         wr_data <= '0;
      end else if (strobe_ok) begin
         if (low_cnt != CNT_MAX) low_cnt <= low_cnt + CW'(1);
         wr_addr <= addr;
         wr_data <= wdata;
      end else begin
         low_cnt <= '0;
      end
   end

   assign wr_valid = we_n && !ce_n && oe_n && (low_cnt == CNT_MAX);

   p_min_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(!we_n && !ce_n && oe_n));
   p_single_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);
endmodule

// File: rtl/pflash_lockout.sv
module pflash_lockout #(
   parameter int LOCK_CYC = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   output logic locked
);
   generate
      if (LOCK_CYC == 0) begin : g_no_delay
         assign locked = !pwr_good;
      end else begin : g_delay
         localparam int LW = $clog2(LOCK_CYC + 1);
         localparam logic [LW-1:0] LOCK_END = LW'(LOCK_CYC);
         logic [LW-1:0] wait_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   wait_cnt <= '0;
            else if (!pwr_good)           wait_cnt <= '0;
            else if (wait_cnt != LOCK_END) wait_cnt <= wait_cnt + LW'(1);
         end

         assign locked = !pwr_good || (wait_cnt != LOCK_END);

         p_rise_locks_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwr_good) |=> locked);
      end
   endgenerate

   p_off_locks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |-> locked);
endmodule

// File: rtl/pflash_cmd_dec.sv
module pflash_cmd_dec
   import pflash_pkg::*;
#(
   parameter int AW = 16,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          wr_valid,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   output logic          prog_req,
   output logic [IW-1:0] prog_idx,
   output logic [7:0]    prog_data
);
   localparam logic [AW-1:0] ADDR_HI = AW'(KEY_ADDR_HI);
   localparam logic [AW-1:0] ADDR_LO = AW'(KEY_ADDR_LO);

   seq_state_e state, state_nx;
   logic       take;

   assign take = wr_valid && enable;

   always_comb begin
      state_nx = state;
      if (take) begin
         unique case (state)
            SEQ_IDLE: state_nx = (wr_addr == ADDR_HI && wr_data == KEY_FIRST)   ? SEQ_ARM1 : SEQ_IDLE;
            SEQ_ARM1: state_nx = (wr_addr == ADDR_LO && wr_data == KEY_SECOND)  ? SEQ_ARM2 : SEQ_IDLE;
            SEQ_ARM2: state_nx = (wr_addr == ADDR_HI && wr_data == KEY_PROGRAM) ? SEQ_LOAD : SEQ_IDLE;
            SEQ_LOAD: state_nx = SEQ_IDLE;
            default:  state_nx = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEQ_IDLE;
      else        state <= state_nx;
   end

   assign prog_req  = take && (state == SEQ_LOAD);
   assign prog_idx  = wr_addr[IW-1:0];
   assign prog_data = wr_data;

   p_load_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |=> state == SEQ_IDLE);
   p_arm2_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_ARM2) |-> ($past(state) == SEQ_ARM1 || $past(state) == SEQ_ARM2));
endmodule

// File: rtl/pflash_wp_seq.sv
module pflash_wp_seq #(
   parameter int AW         = 16,
   parameter int ARRAY_AW   = 4,
   parameter int MIN_WE_CYC = 2,
   parameter int LOCK_CYC   = 500000,
   parameter int PROG_CYC   = 5000000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   input  logic          pwr_good,
   input  logic          vdd_low,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << ARRAY_AW;
   localparam int PW    = $clog2(PROG_CYC + 1);
   localparam logic [PW-1:0] TMR_LOAD = PW'(PROG_CYC - 1);

   generate
      if (AW < 15)                    begin : g_bad_aw    $error("AW too small for unlock addresses"); end
      if (ARRAY_AW < 1 || ARRAY_AW > AW) begin : g_bad_arr $error("ARRAY_AW out of range"); end
      if (MIN_WE_CYC < 1)             begin : g_bad_we    $error("MIN_WE_CYC must be at least 1"); end
      if (PROG_CYC < 1)               begin : g_bad_prog  $error("PROG_CYC must be at least 1"); end
   endgenerate

   logic                wr_valid;
   logic [AW-1:0]       wr_addr;
   logic [7:0]          wr_data;
   logic                locked;
   logic                prog_req;
   logic [ARRAY_AW-1:0] prog_idx;
   logic [7:0]          prog_data;

   logic                busy_q;
   logic [PW-1:0]       tmr_q;
   logic [ARRAY_AW-1:0] paddr_q;
   logic [7:0]          pdata_q;
   logic                toggle_q;
   logic                rd_q;
   logic [7:0]          mem [DEPTH];
   logic                rd_act;
   logic                start;

   pflash_we_qual #(.AW(AW), .MIN_WE_CYC(MIN_WE_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .wdata(wdata),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

   pflash_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .locked(locked));

   pflash_cmd_dec #(.AW(AW), .IW(ARRAY_AW)) u_dec (
      .clk(clk), .rst_n(rst_n), .enable(!busy_q),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .prog_req(prog_req), .prog_idx(prog_idx), .prog_data(prog_data));

   assign rd_act = !ce_n && !oe_n && we_n;
   assign start  = prog_req && !locked && !vdd_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         tmr_q    <= '0;
         paddr_q  <= '0;
         pdata_q  <= 8'hFF;
         toggle_q <= 1'b0;
         rd_q     <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else begin
         rd_q <= rd_act;
         if (busy_q && rd_act && !rd_q) toggle_q <= !toggle_q;
         if (start) begin
            busy_q  <= 1'b1;
            tmr_q   <= TMR_LOAD;
            paddr_q <= prog_idx;
            pdata_q <= prog_data;
         end else if (busy_q) begin
            if (tmr_q == '0) begin
               busy_q        <= 1'b0;
               mem[paddr_q]  <= mem[paddr_q] & pdata_q;
            end else begin
               tmr_q <= tmr_q - PW'(1);
            end
         end
      end
   end

   always_comb begin
      if (!rd_act)     rdata = 8'h00;
      else if (busy_q) rdata = {~pdata_q[7], toggle_q, 6'b000000};
      else             rdata = mem[addr[ARRAY_AW-1:0]];
   end

   p_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> ((mem[paddr_q] & ~$past(mem[paddr_q])) == 8'h00));
   p_gated_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(!locked && !vdd_low));
   p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && tmr_q != '0) |=> (busy_q && $stable(paddr_q) && $stable(pdata_q)));
endmodule

// File: tb/pflash_wp_seq_tb.sv
module pflash_wp_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int MIN_WE     = 3;
   localparam int LOCK       = 40;
   localparam int PROG       = 30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        pwr_good = 1'b0, vdd_low = 1'b0;
   logic [7:0]  rdata;

   int checks = 0;
   int fails  = 0;
   logic [7:0] model [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   pflash_wp_seq #(.AW(16), .ARRAY_AW(4), .MIN_WE_CYC(MIN_WE), .LOCK_CYC(LOCK), .PROG_CYC(PROG)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .wdata(wdata), .pwr_good(pwr_good), .vdd_low(vdd_low), .rdata(rdata));

   function automatic logic [7:0] prog_result(logic [7:0] old_v, logic [7:0] d);
      return old_v & d;
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // mode 0 normal, 1 read strobe low, 2 chip select high
   task automatic bus_write(logic [15:0] a, logic [7:0] d, int len, int mode);
      @(negedge clk);
      addr = a; wdata = d;
      ce_n = (mode == 2); oe_n = (mode != 1);
      @(negedge clk);
      we_n = 1'b0;
      repeat (len) @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic bus_read(logic [15:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      v = rdata;
      ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_prog(logic [15:0] a, logic [7:0] d, logic [7:0] k1, int len1, int mode1);
      bus_write(16'h5555, k1, len1, mode1);
      bus_write(16'h2AAA, 8'h55, MIN_WE, 0);
      bus_write(16'h5555, 8'hA0, MIN_WE, 0);
      bus_write(a, d, MIN_WE, 0);
   endtask

   task automatic poll_done(logic [7:0] d, string tag, output int nread);
      logic [7:0] v1, v2;
      logic       first = 1'b1;
      nread = 0;
      forever begin
         bus_read(16'h0000, v1);
         if (first) begin
            chk({tag, " R8 status bit7/low bits"}, v1 & 8'hBF, {~d[7], 7'b0});
            first = 1'b0;
         end
         bus_read(16'h0000, v2);
         nread += 2;
         if (v1[6] == v2[6] || nread > 40) break;
      end
   endtask

   task automatic expect_idle(logic [3:0] a, string tag);
      logic [7:0] v1, v2;
      bus_read({12'h0, a}, v1);
      bus_read({12'h0, a}, v2);
      chk({tag, " byte unchanged"}, v1, model[a]);
      chk({tag, " not busy"}, v2, v1);
   endtask

   task automatic do_program(logic [3:0] a, logic [7:0] d, string tag);
      int n;
      logic [7:0] v;
      send_prog({12'h0, a}, d, 8'hAA, MIN_WE, 0);
      poll_done(d, tag, n);
      checks++;
      if (n < 2 || n > 2 * (PROG / 6 + 3)) begin
         fails++;
         $display("FAIL %s R9 poll reads: actual %0d expected 2..%0d", tag, n, 2 * (PROG / 6 + 3));
      end
      model[a] = prog_result(model[a], d);
      bus_read({12'h0, a}, v);
      chk({tag, " R2 R9 array value"}, v, model[a]);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      logic [7:0] v;
      int n;
      void'($urandom(32'd20240517));
      for (int i = 0; i < 16; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 idle rdata", rdata, 8'h00);
      for (int i = 0; i < 16; i++) begin
         bus_read(16'(i), v);
         chk("R1 erased array", v, 8'hFF);
      end

      // R6 supply not good
      send_prog(16'h0001, 8'h00, 8'hAA, MIN_WE, 0);
      expect_idle(4'd1, "R6 pwr_good low");
      // R6 inside lockout window
      pwr_good = 1'b1;
      send_prog(16'h0002, 8'h0F, 8'hAA, MIN_WE, 0);
      expect_idle(4'd2, "R6 lockout window");
      repeat (LOCK + 10) @(negedge clk);

      // R7 low supply
      vdd_low = 1'b1;
      send_prog(16'h0003, 8'h00, 8'hAA, MIN_WE, 0);
      expect_idle(4'd3, "R7 vdd_low");
      vdd_low = 1'b0;

      // R4 short pulse on first unlock write
      send_prog(16'h0004, 8'h00, 8'hAA, MIN_WE - 1, 0);
      expect_idle(4'd4, "R4 short pulse");
      // R5 inhibit strobes
      send_prog(16'h0004, 8'h00, 8'hAA, MIN_WE, 1);
      expect_idle(4'd4, "R5 oe low");
      send_prog(16'h0004, 8'h00, 8'hAA, MIN_WE, 2);
      expect_idle(4'd4, "R5 ce high");

      // R3 wrong key, wrong address in step two
      send_prog(16'h0004, 8'h00, 8'hAB, MIN_WE, 0);
      expect_idle(4'd4, "R3 bad key");
      bus_write(16'h5555, 8'hAA, MIN_WE, 0);
      bus_write(16'h2AAB, 8'h55, MIN_WE, 0);
      bus_write(16'h5555, 8'hA0, MIN_WE, 0);
      bus_write(16'h0004, 8'h00, MIN_WE, 0);
      expect_idle(4'd4, "R3 bad address");

      // R2 R8 R9 directed
      do_program(4'd5, 8'h5A, "R2 first");
      do_program(4'd5, 8'hF0, "R2 no set");
      do_program(4'd4, 8'h7F, "R8 bit7 zero");

      // R10 sequence during busy
      send_prog(16'h0006, 8'h00, 8'hAA, MIN_WE, 0);
      send_prog(16'h0007, 8'h00, 8'hAA, MIN_WE, 0);
      poll_done(8'h00, "R10", n);
      model[6] = 8'h00;
      bus_read(16'h0006, v);
      chk("R10 first program", v, 8'h00);
      expect_idle(4'd7, "R10 busy write dropped");

      // random programs
      for (int k = 0; k < 30; k++) begin
         logic [3:0] ra;
         logic [7:0] rd;
         ra = 4'($urandom % 16);
         rd = 8'($urandom);
         do_program(ra, rd, "R2 random");
      end
      for (int i = 0; i < 16; i++) begin
         bus_read(16'(i), v);
         chk("R9 final array", v, model[i]);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule